// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Aggregator

This block collects interrupt events for a serial controller with two channels (A and B) and turns them into one level interrupt for the host. Each channel holds two sticky event status bytes, and each byte has its own mask byte. A port event source is shared by both channels and has one status byte and one mask byte. Event pulses on the input ports set status bits. The host reads and clears the status bytes through a byte-wide register bus that has a channel select.

From the five status/mask pairs the block forms a summary byte. Either channel can read it. A summary bit is set when the status byte for that bit has any bit set whose mask bit is clear. The interrupt line follows the summary only while the power-up bit in channel A's control byte is set. A pending, unmasked port event drives the line in every power state.

Top module: `dual_irq_summary`

## Requirements
- R1: After reset all status bytes read 0x00, all mask bytes read 0xFF, both control bytes read 0x00, the summary reads 0x00 and `irq_o` is low.
- R2: Each summary bit is 1 exactly when (status AND NOT mask) is non-zero for its source. The positions are: bit 7 port, bit 3 channel A status 1, bit 2 channel A status 0, bit 1 channel B status 1, bit 0 channel B status 0. Bits 6..4 read as 0.
- R3: The summary byte reads the same value through either channel select (`bus_ch` 0 = A, 1 = B).
- R4: `irq_o` is a registered level. It is high one clock after (summary non-zero AND channel A control bit 7 set), or after a pending unmasked port event. It is low one clock after neither condition holds.
- R5: While channel A control bit 7 is 0, channel status sources do not raise `irq_o`. Channel B's control bit 7 has no effect on `irq_o`.
- R6: A pending unmasked port event raises `irq_o` even while channel A control bit 7 is 0.
- R7: A read of status 0 or status 1 returns the current value and clears that byte of the selected channel only, at the same clock edge.
- R8: A read of the port status through either channel returns its value and clears the single shared port status byte.
- R9: An event bit that arrives in the same cycle as a clearing read of its byte is kept set after the read.
- R10: Address map (6-bit): 0x2C control, 0x38 summary, 0x3A status 0, 0x3B status 1, 0x3C mask 0, 0x3D mask 1, 0x3E port status, 0x3F port mask. Control and mask bytes are writable and read back what was written. Writes to the status and summary addresses have no effect. Unmapped addresses read 0x00.
- R11: Event pulses OR into a status byte, so bits from separate pulses accumulate until the byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ch | input | 1 | Channel select, 0 = A, 1 = B |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| ev_a0 | input | 8 | Event set pulses, channel A status 0 |
| ev_a1 | input | 8 | Event set pulses, channel A status 1 |
| ev_b0 | input | 8 | Event set pulses, channel B status 0 |
| ev_b1 | input | 8 | Event set pulses, channel B status 1 |
| ev_port | input | 8 | Event set pulses, shared port status |
| irq_o | output | 1 | Interrupt level to the host, active high |

## Verification
A stale or wrongly cleared status byte shows up as a wrong summary value on the next read. It also changes `irq_o` one clock after the faulty edge. A clear that reaches the wrong channel, or that drops a coincident event, appears in the status read that follows the clearing read. Power gating faults show as `irq_o` staying low, or rising, exactly one cycle after a control or mask write.

// File: rtl/dual_irq_summary.sv
module dual_irq_summary #(
  parameter int AW = 6,
  parameter logic [AW-1:0] OFS_CTL  = 6'h2C,
  parameter logic [AW-1:0] OFS_SUM  = 6'h38,
  parameter logic [AW-1:0] OFS_ST0  = 6'h3A,
  parameter logic [AW-1:0] OFS_ST1  = 6'h3B,
  parameter logic [AW-1:0] OFS_MK0  = 6'h3C,
  parameter logic [AW-1:0] OFS_MK1  = 6'h3D,
  parameter logic [AW-1:0] OFS_PST  = 6'h3E,
  parameter logic [AW-1:0] OFS_PMK  = 6'h3F,
  parameter int PWR_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ch,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    ev_a0,
  input  logic [7:0]    ev_a1,
  input  logic [7:0]    ev_b0,
  input  logic [7:0]    ev_b1,
  input  logic [7:0]    ev_port,
  output logic          irq_o
);
  localparam int NCH = 2;

  logic [7:0] st0 [NCH];
  logic [7:0] st1 [NCH];
  logic [7:0] mk0 [NCH];
  logic [7:0] mk1 [NCH];
  logic [7:0] ctl [NCH];
  logic [7:0] ev0 [NCH];
  logic [7:0] ev1 [NCH];
  logic [7:0] pst, pmk, summary;
  logic       p_pend, pwr_up, irq_next;

  assign ev0[0] = ev_a0;
  assign ev0[1] = ev_b0;
  assign ev1[0] = ev_a1;
  assign ev1[1] = ev_b1;

  wire rd_st0 = bus_rd && (bus_addr == OFS_ST0);
  wire rd_st1 = bus_rd && (bus_addr == OFS_ST1);
  wire rd_pst = bus_rd && (bus_addr == OFS_PST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        st0[c] <= '0;
        st1[c] <= '0;
        mk0[c] <= '1;
        mk1[c] <= '1;
        ctl[c] <= '0;
      end
      pst <= '0;
      pmk <= '1;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        st0[c] <= ((rd_st0 && bus_ch == 1'(c)) ? 8'h00 : st0[c]) | ev0[c];
        st1[c] <= ((rd_st1 && bus_ch == 1'(c)) ? 8'h00 : st1[c]) | ev1[c];
        if (bus_wr && bus_ch == 1'(c)) begin
          if (bus_addr == OFS_MK0) mk0[c] <= bus_wdata;
          if (bus_addr == OFS_MK1) mk1[c] <= bus_wdata;
          if (bus_addr == OFS_CTL) ctl[c] <= bus_wdata;
        end
      end
      pst <= (rd_pst ? 8'h00 : pst) | ev_port;
      if (bus_wr && bus_addr == OFS_PMK) pmk <= bus_wdata;
    end
  end

  assign p_pend  = |(pst & ~pmk);
  assign summary = {p_pend, 3'b000,
                    |(st1[0] & ~mk1[0]), |(st0[0] & ~mk0[0]),
                    |(st1[1] & ~mk1[1]), |(st0[1] & ~mk0[1])};
  assign pwr_up   = ctl[0][PWR_BIT];
  assign irq_next = p_pend || ((summary != 8'h00) && pwr_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_next;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTL: bus_rdata = ctl[bus_ch];
      OFS_SUM: bus_rdata = summary;
      OFS_ST0: bus_rdata = st0[bus_ch];
      OFS_ST1: bus_rdata = st1[bus_ch];
      OFS_MK0: bus_rdata = mk0[bus_ch];
      OFS_MK1: bus_rdata = mk1[bus_ch];
      OFS_PST: bus_rdata = pst;
      OFS_PMK: bus_rdata = pmk;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R4: a zero summary cannot leave the line high on the next cycle
  a_r4_no_irq_without_source: assert property (@(posedge clk) disable iff (!rst_n)
    (summary == 8'h00) |=> !irq_o);

  // R5: powered down with no port source keeps the line low
  a_r5_powerdown_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[0][PWR_BIT] && !summary[7]) |=> !irq_o);

  // R6: unmasked port status raises the line whatever the power state
  a_r6_port_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ((pst & ~pmk) != 8'h00) |=> irq_o);

  // R7: clearing read of channel A status 0 with no new event empties it
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_ST0 && !bus_ch && ev_a0 == 8'h00) |=> (st0[0] == 8'h00));

  // R8: port status read from any channel empties the shared byte
  a_r8_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_PST && ev_port == 8'h00) |=> (pst == 8'h00));

  // R9: an incoming event is never dropped by a simultaneous read
  a_r9_no_event_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a0 != 8'h00) |=> ((st0[0] & $past(ev_a0)) == $past(ev_a0)));
endmodule

// File: tb/dual_irq_summary_tb_top.sv
module dual_irq_summary_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_ch = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ev_a0 = '0, ev_a1 = '0, ev_b0 = '0, ev_b1 = '0, ev_port = '0;
  logic       irq_o;
  int checks = 0;
  int fails = 0;

  localparam logic [5:0] A_CTL = 6'h2C, A_SUM = 6'h38, A_ST0 = 6'h3A, A_ST1 = 6'h3B,
                         A_MK0 = 6'h3C, A_MK1 = 6'h3D, A_PST = 6'h3E, A_PMK = 6'h3F;

  always #10 clk = ~clk;

  dual_irq_summary dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ch(bus_ch), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_a0(ev_a0), .ev_a1(ev_a1), .ev_b0(ev_b0), .ev_b1(ev_b1), .ev_port(ev_port),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%02h exp=0x%02h", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic rd(input logic ch, input logic [5:0] a, output logic [7:0] d);
    bus_ch = ch; bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic ch, input logic [5:0] a, input logic [7:0] d);
    bus_ch = ch; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] p);
    ev_a0 = a0; ev_a1 = a1; ev_b0 = b0; ev_b1 = b1; ev_port = p;
    @(negedge clk);
    ev_a0 = '0; ev_a1 = '0; ev_b0 = '0; ev_b1 = '0; ev_port = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rd(1'b0, A_SUM, d); chk("R1 summary", d, 8'h00);
    rd(1'b1, A_MK1, d); chk("R1 mask1 B", d, 8'hFF);
    rd(1'b0, A_PMK, d); chk("R1 port mask", d, 8'hFF);
    rd(1'b0, A_CTL, d); chk("R1 ctl A", d, 8'h00);
    rd(1'b1, A_ST0, d); chk("R1 status0 B", d, 8'h00);
  endtask

  task automatic t_masked_then_powered();
    logic [7:0] d;
    pulse(8'h01, 0, 0, 0, 0); settle();
    chk("R2 masked no irq", {7'b0, irq_o}, 8'h00);
    rd(1'b0, A_SUM, d); chk("R2 masked summary", d, 8'h00);
    wr(1'b0, A_CTL, 8'h80);
    wr(1'b0, A_MK0, 8'hFE);
    chk("R4 one-cycle latency", {7'b0, irq_o}, 8'h00);
    settle();
    chk("R4 irq raised", {7'b0, irq_o}, 8'h01);
    rd(1'b0, A_SUM, d); chk("R2 summary A0", d, 8'h04);
    rd(1'b1, A_SUM, d); chk("R3 summary via B", d, 8'h04);
    rd(1'b0, A_ST0, d); chk("R7 read value", d, 8'h01);
    rd(1'b0, A_ST0, d); chk("R7 cleared", d, 8'h00);
    chk("R4 irq dropped", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_pattern();
    logic [7:0] d;
    wr(1'b0, A_MK0, 8'h00); wr(1'b0, A_MK1, 8'h00);
    wr(1'b1, A_MK0, 8'h00); wr(1'b1, A_MK1, 8'h00);
    pulse(0, 8'h10, 8'h02, 8'h80, 0); settle();
    chk("R4 irq multi", {7'b0, irq_o}, 8'h01);
    rd(1'b1, A_SUM, d); chk("R2 summary multi", d, 8'h0B);
    rd(1'b1, A_ST1, d); chk("R7 B status1 value", d, 8'h80);
    rd(1'b0, A_ST1, d); chk("R7 A status1 untouched", d, 8'h10);
    rd(1'b0, A_SUM, d); chk("R2 summary after clears", d, 8'h01);
    rd(1'b1, A_ST0, d); chk("R7 B status0 value", d, 8'h02);
    settle();
    chk("R4 irq idle", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_powerdown();
    logic [7:0] d;
    wr(1'b0, A_CTL, 8'h00);
    wr(1'b1, A_CTL, 8'h80);
    pulse(8'h01, 0, 0, 0, 0); settle(); settle();
    chk("R5 gated irq", {7'b0, irq_o}, 8'h00);
    rd(1'b0, A_SUM, d); chk("R5 summary still set", d, 8'h04);
    rd(1'b1, A_CTL, d); chk("R10 ctl B readback", d, 8'h80);
    rd(1'b0, A_ST0, d);
  endtask

  task automatic t_port();
    logic [7:0] d;
    wr(1'b1, A_PMK, 8'h00);
    rd(1'b0, A_PMK, d); chk("R10 port mask shared", d, 8'h00);
    pulse(0, 0, 0, 0, 8'h04); settle();
    chk("R6 port bypass irq", {7'b0, irq_o}, 8'h01);
    rd(1'b0, A_SUM, d); chk("R2 summary port", d, 8'h80);
    rd(1'b1, A_PST, d); chk("R8 port read B", d, 8'h04);
    rd(1'b0, A_PST, d); chk("R8 port cleared A", d, 8'h00);
    chk("R6 irq low after clear", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_coincident();
    logic [7:0] d;
    pulse(8'h01, 0, 0, 0, 8'h01);
    ev_a0 = 8'h02; ev_port = 8'h08;
    rd(1'b0, A_ST0, d);
    ev_a0 = '0; ev_port = '0;
    chk("R9 read old value", d, 8'h01);
    rd(1'b0, A_ST0, d); chk("R9 event kept", d, 8'h02);
    ev_port = 8'h10;
    rd(1'b1, A_PST, d);
    ev_port = '0;
    chk("R9 port old value", d, 8'h09);
    rd(1'b0, A_PST, d); chk("R9 port event kept", d, 8'h10);
  endtask

  task automatic t_accumulate_and_map();
    logic [7:0] d;
    pulse(0, 0, 8'h01, 0, 0);
    pulse(0, 0, 8'h40, 0, 0);
    rd(1'b1, A_ST0, d); chk("R11 accumulated", d, 8'h41);
    pulse(0, 8'h20, 0, 0, 0);
    wr(1'b0, A_ST1, 8'h00); wr(1'b0, A_SUM, 8'hFF);
    rd(1'b0, A_ST1, d); chk("R10 status write ignored", d, 8'h20);
    wr(1'b0, A_ST0, 8'hFF);
    rd(1'b0, A_ST0, d); chk("R10 status0 write ignored", d, 8'h00);
    rd(1'b0, 6'h00, d); chk("R10 unmapped", d, 8'h00);
    wr(1'b1, A_MK1, 8'h5A);
    rd(1'b1, A_MK1, d); chk("R10 mask readback", d, 8'h5A);
    rd(1'b0, A_MK1, d); chk("R10 mask per channel", d, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_masked_then_powered();
    t_pattern();
    t_powerdown();
    t_port();
    t_coincident();
    t_accumulate_and_map();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule